// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block owns the processor's 32-bit status word together with one saved status copy and one link register for each of the five exception modes. Each clock it looks at the pending exception requests (hard reset request, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt, fast interrupt). When one is eligible, it performs the whole entry in a single clock edge. It saves the old status and the supplied return address into the banks of the target mode. It rewrites the status word and loads the program counter with the exception's vector.

A return strobe does the reverse. The status word is restored from the current mode's saved copy and the program counter from the current mode's link register. A plain status write port lets the surrounding core set flags, masks, state bits and mode between events. The block has no instruction decode, no general register file and no memory interface. It only decides what the next PC and status word are and announces the change with one-cycle pulses.

Top module: `trap_unit`

## Requirements
- R1: After the asynchronous active-low reset, the status word reads 0x000000D3 (supervisor mode, both interrupt masks set), `pcNext` is 0, and `pcLoad`, `excTaken` and `retTaken` are 0.
- R2: Status bit positions are N=31, Z=30, C=29, V=28, sticky saturation=27, bytecode state=24, IRQ mask=7, FIQ mask=6, compressed state=5, mode=[4:0]. A status write stores `statusWrData & 0xF90000FF` on the next edge.
- R3: On entry, the status word as it stood before the entry is stored in the saved copy of the target mode. This is observed through a later return.
- R4: On entry, the mode field takes the target mode (user 10000, FIQ 10001, IRQ 10010, supervisor 10011, abort 10111, undefined 11011, system 11111), bits 5 and 24 are cleared, bit 7 is set, and the flag bits are unchanged.
- R5: Bit 6 is set on entry for reset and FIQ only; every other exception leaves it unchanged.
- R6: The vector address is `VEC_BASE` plus 4 × code. The code is shown on `excCode`: reset 0 (supervisor), undefined 1 (undefined), software interrupt 2 (supervisor), prefetch abort 3 (abort), data abort 4 (abort), IRQ 6, FIQ 7.
- R7: On entry, `curPc` is stored in the link register of the target mode. This is observed through a later return.
- R8: Exceptions other than reset are taken only in a cycle with `execDone` high. A reset request is taken at once.
- R9: Simultaneous eligible requests are resolved in this order: reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R10: An IRQ request is not eligible while bit 7 is set, and an FIQ request is not eligible while bit 6 is set.
- R11: A return loads the status from the current mode's saved copy and `pcNext` from its link register, and pulses `retTaken`. It is ignored (no output changes) when bit 5 or bit 24 is set or when the mode has no bank (user, system, or an undefined encoding).
- R12: In a cycle where an exception is taken, a return strobe and a status write are both ignored. An accepted return overrides a status write.
- R13: `excTaken`, `retTaken` and `pcLoad` are single-cycle pulses, asserted in the cycle after the edge that performed the entry or return. `pcLoad` is high only with one of the other two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqReset | input | 1 | Reset exception request |
| reqUndef | input | 1 | Undefined instruction request |
| reqSwi | input | 1 | Software interrupt request |
| reqPabt | input | 1 | Prefetch abort request |
| reqDabt | input | 1 | Data abort request |
| irqReq | input | 1 | Normal interrupt line |
| fiqReq | input | 1 | Fast interrupt line |
| execDone | input | 1 | Instruction in execute completes this cycle |
| curPc | input | PC_W | Return address to bank on entry |
| retStrobe | input | 1 | Exception return request |
| statusWr | input | 1 | Status word write enable |
| statusWrData | input | 32 | Status word write value |
| statusOut | output | 32 | Current status word |
| pcNext | output | PC_W | New program counter |
| pcLoad | output | 1 | pcNext valid pulse |
| excTaken | output | 1 | Exception entry pulse |
| excCode | output | 3 | Code of the last exception taken |
| retTaken | output | 1 | Return accepted pulse |

## Verification
Exception entry and return can be requested in the same cycle, and each of them can also coincide with a status write. The bench provokes this directly: one cycle raises an undefined instruction request with `execDone`, together with a return strobe and a status write. It expects the entry alone, with the status saved being the pre-write value. A long stretch of random stimulus then repeats such collisions many times. Every cycle, the bench compares the outputs against a behavioural model that applies the precedence entry, then accepted return, then write.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int STAT_W = 32;
  localparam int MODE_W = 5;
  localparam int NUM_BANKS = 5;
  localparam int BANK_W = $clog2(NUM_BANKS);

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  localparam int BIT_J = 24;
  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;

  localparam logic [STAT_W-1:0] STAT_WR_MASK = 32'hF900_00FF;
  localparam logic [STAT_W-1:0] STAT_RESET   = 32'h0000_00D3;

  typedef enum logic [2:0] {
    VEC_RESET = 3'd0,
    VEC_UNDEF = 3'd1,
    VEC_SWI   = 3'd2,
    VEC_PABT  = 3'd3,
    VEC_DABT  = 3'd4,
    VEC_RSVD  = 3'd5,
    VEC_IRQ   = 3'd6,
    VEC_FIQ   = 3'd7
  } vecKind_t;

  typedef struct packed {
    logic            enter;
    logic            ret;
    logic            wr;
    vecKind_t        kind;
    logic [MODE_W-1:0] newMode;
    logic            maskFiq;
  } ctlStrobe_t;

  function automatic logic [BANK_W-1:0] bankOf(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return BANK_W'(0);
      MODE_IRQ: return BANK_W'(1);
      MODE_SVC: return BANK_W'(2);
      MODE_ABT: return BANK_W'(3);
      MODE_UND: return BANK_W'(4);
      default:  return BANK_W'(0);
    endcase
  endfunction

  function automatic logic bankValid(input logic [MODE_W-1:0] m);
    return (m == MODE_FIQ) || (m == MODE_IRQ) || (m == MODE_SVC) ||
           (m == MODE_ABT) || (m == MODE_UND);
  endfunction

  function automatic logic [MODE_W-1:0] modeOf(input vecKind_t k);
    case (k)
      VEC_RESET, VEC_SWI: return MODE_SVC;
      VEC_UNDEF:          return MODE_UND;
      VEC_PABT, VEC_DABT: return MODE_ABT;
      VEC_IRQ:            return MODE_IRQ;
      default:            return MODE_FIQ;
    endcase
  endfunction

endpackage

// File: rtl/trap_ctl.sv
module trap_ctl
  import trap_pkg::*;
(
  input  logic              reqReset,
  input  logic              reqUndef,
  input  logic              reqSwi,
  input  logic              reqPabt,
  input  logic              reqDabt,
  input  logic              irqReq,
  input  logic              fiqReq,
  input  logic              execDone,
  input  logic              retStrobe,
  input  logic              statusWr,
  input  logic [STAT_W-1:0] curStatus,
  output ctlStrobe_t        strobe
);

  logic     hit;
  vecKind_t kind;
  logic     irqOk;
  logic     fiqOk;
  logic     retOk;

  assign irqOk = irqReq && !curStatus[BIT_I];
  assign fiqOk = fiqReq && !curStatus[BIT_F];

  // fixed priority: reset ignores execDone, the rest wait for it
  always_comb begin
    hit  = 1'b1;
    kind = VEC_RESET;
    if (reqReset)      kind = VEC_RESET;
    else if (!execDone) hit = 1'b0;
    else if (reqDabt)  kind = VEC_DABT;
    else if (fiqOk)    kind = VEC_FIQ;
    else if (irqOk)    kind = VEC_IRQ;
    else if (reqPabt)  kind = VEC_PABT;
    else if (reqUndef) kind = VEC_UNDEF;
    else if (reqSwi)   kind = VEC_SWI;
    else               hit = 1'b0;
  end

  assign retOk = retStrobe && !curStatus[BIT_T] && !curStatus[BIT_J] &&
                 bankValid(curStatus[MODE_W-1:0]);

  always_comb begin
    strobe         = '0;
    strobe.enter   = hit;
    strobe.kind    = kind;
    strobe.newMode = modeOf(kind);
    strobe.maskFiq = (kind == VEC_RESET) || (kind == VEC_FIQ);
    strobe.ret     = !hit && retOk;
    strobe.wr      = !hit && !retOk && statusWr;
  end

endmodule

// File: rtl/trap_dp.sv
module trap_dp
  import trap_pkg::*;
#(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [PC_W-1:0]   curPc,
  input  logic [STAT_W-1:0] wrData,
  output logic [STAT_W-1:0] statusQ,
  output logic [PC_W-1:0]   pcQ,
  output logic              pcLoadQ,
  output logic              takenQ,
  output logic [2:0]        codeQ,
  output logic              retQ
);

  logic [STAT_W-1:0] savedArr [NUM_BANKS];
  logic [PC_W-1:0]   linkArr  [NUM_BANKS];
  logic [BANK_W-1:0] curBank;
  logic [BANK_W-1:0] tgtBank;
  logic [STAT_W-1:0] entryStat;

  assign curBank = bankOf(statusQ[MODE_W-1:0]);
  assign tgtBank = bankOf(strobe.newMode);

  always_comb begin
    entryStat               = statusQ;
    entryStat[MODE_W-1:0]   = strobe.newMode;
    entryStat[BIT_T]        = 1'b0;
    entryStat[BIT_J]        = 1'b0;
    entryStat[BIT_I]        = 1'b1;
    if (strobe.maskFiq) entryStat[BIT_F] = 1'b1;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              saveHere;
    logic [STAT_W-1:0] savedQ;
    logic [PC_W-1:0]   linkQ;

    assign saveHere = strobe.enter && (tgtBank == BANK_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        savedQ <= '0;
        linkQ  <= '0;
      end else if (saveHere) begin
        savedQ <= statusQ;
        linkQ  <= curPc;
      end
    end

    assign savedArr[b] = savedQ;
    assign linkArr[b]  = linkQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= STAT_RESET;
      pcQ     <= '0;
      pcLoadQ <= 1'b0;
      takenQ  <= 1'b0;
      codeQ   <= 3'd0;
      retQ    <= 1'b0;
    end else begin
      pcLoadQ <= strobe.enter || strobe.ret;
      takenQ  <= strobe.enter;
      retQ    <= strobe.ret;
      if (strobe.enter) begin
        statusQ <= entryStat;
        pcQ     <= VEC_BASE + PC_W'({strobe.kind, 2'b00});
        codeQ   <= strobe.kind;
      end else if (strobe.ret) begin
        statusQ <= savedArr[curBank];
        pcQ     <= linkArr[curBank];
      end else if (strobe.wr) begin
        statusQ <= wrData & STAT_WR_MASK;
      end
    end
  end

endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] VEC_BASE = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqReset,
  input  logic            reqUndef,
  input  logic            reqSwi,
  input  logic            reqPabt,
  input  logic            reqDabt,
  input  logic            irqReq,
  input  logic            fiqReq,
  input  logic            execDone,
  input  logic [PC_W-1:0] curPc,
  input  logic            retStrobe,
  input  logic            statusWr,
  input  logic [31:0]     statusWrData,
  output logic [31:0]     statusOut,
  output logic [PC_W-1:0] pcNext,
  output logic            pcLoad,
  output logic            excTaken,
  output logic [2:0]      excCode,
  output logic            retTaken
);

  ctlStrobe_t strobe;

  trap_ctl u_ctl (
    .reqReset  (reqReset),
    .reqUndef  (reqUndef),
    .reqSwi    (reqSwi),
    .reqPabt   (reqPabt),
    .reqDabt   (reqDabt),
    .irqReq    (irqReq),
    .fiqReq    (fiqReq),
    .execDone  (execDone),
    .retStrobe (retStrobe),
    .statusWr  (statusWr),
    .curStatus (statusOut),
    .strobe    (strobe)
  );

  trap_dp #(.PC_W(PC_W), .VEC_BASE(VEC_BASE)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .curPc   (curPc),
    .wrData  (statusWrData),
    .statusQ (statusOut),
    .pcQ     (pcNext),
    .pcLoadQ (pcLoad),
    .takenQ  (excTaken),
    .codeQ   (excCode),
    .retQ    (retTaken)
  );

endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] VEC_BASE = '0
) (
  input logic            clk,
  input logic            rstN,
  input logic            execDone,
  input logic [31:0]     statusOut,
  input logic [PC_W-1:0] pcNext,
  input logic            pcLoad,
  input logic            excTaken,
  input logic [2:0]      excCode,
  input logic            retTaken
);

  // R6
  vec_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> pcLoad && (pcNext == VEC_BASE + PC_W'({excCode, 2'b00})));

  // R4
  entry_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> statusOut[7] && !statusOut[5] && !statusOut[24]);

  // R5
  fiq_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excTaken && excCode != 3'd0 && excCode != 3'd7) |-> (statusOut[6] == $past(statusOut[6])));

  // R8
  exec_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excTaken && excCode != 3'd0) |-> $past(execDone));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excTaken && excCode == 3'd6) |-> !$past(statusOut[7]));

  // R12
  excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(excTaken && retTaken));

  // R11
  ret_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    retTaken |-> pcLoad && !$past(statusOut[5]) && !$past(statusOut[24]));

  // R13
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> (excTaken || retTaken));

endmodule

bind trap_unit trap_unit_chk #(.PC_W(PC_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .execDone  (execDone),
  .statusOut (statusOut),
  .pcNext    (pcNext),
  .pcLoad    (pcLoad),
  .excTaken  (excTaken),
  .excCode   (excCode),
  .retTaken  (retTaken)
);

// File: tb/sim_trap_unit.sv
module sim_trap_unit;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqReset = 0, reqUndef = 0, reqSwi = 0, reqPabt = 0, reqDabt = 0;
  logic irqReq = 0, fiqReq = 0, execDone = 0, retStrobe = 0, statusWr = 0;
  logic [31:0] curPc = '0;
  logic [31:0] statusWrData = '0;
  logic [31:0] statusOut;
  logic [31:0] pcNext;
  logic        pcLoad, excTaken, retTaken;
  logic [2:0]  excCode;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trap_unit u0 (
    .clk(clk), .rstN(rstN), .reqReset(reqReset), .reqUndef(reqUndef),
    .reqSwi(reqSwi), .reqPabt(reqPabt), .reqDabt(reqDabt), .irqReq(irqReq),
    .fiqReq(fiqReq), .execDone(execDone), .curPc(curPc), .retStrobe(retStrobe),
    .statusWr(statusWr), .statusWrData(statusWrData), .statusOut(statusOut),
    .pcNext(pcNext), .pcLoad(pcLoad), .excTaken(excTaken), .excCode(excCode),
    .retTaken(retTaken)
  );

  // behavioural reference model
  logic [31:0] mSt = 32'h0000_00D3;
  logic [31:0] mPc = '0;
  logic [2:0]  mCode = '0;
  logic        mLoad = 0, mTaken = 0, mRet = 0;
  logic [31:0] mSaved [int];
  logic [31:0] mLink  [int];

  function automatic bit hasBank(logic [4:0] m);
    return m == 5'h11 || m == 5'h12 || m == 5'h13 || m == 5'h17 || m == 5'h1B;
  endfunction

  function automatic logic [4:0] targetMode(int k);
    case (k)
      0, 2:    return 5'h13;
      1:       return 5'h1B;
      3, 4:    return 5'h17;
      6:       return 5'h12;
      default: return 5'h11;
    endcase
  endfunction

  task automatic modelStep();
    int k = -1;
    logic [4:0] md = mSt[4:0];
    logic [4:0] tm;
    bit acc;
    if (reqReset) k = 0;
    else if (execDone) begin
      if (reqDabt) k = 4;
      else if (fiqReq && !mSt[6]) k = 7;
      else if (irqReq && !mSt[7]) k = 6;
      else if (reqPabt) k = 3;
      else if (reqUndef) k = 1;
      else if (reqSwi) k = 2;
    end
    acc = (k < 0) && retStrobe && !mSt[5] && !mSt[24] && hasBank(md);
    mTaken = (k >= 0);
    mRet = acc;
    mLoad = mTaken || acc;
    if (k >= 0) begin
      tm = targetMode(k);
      mSaved[int'(tm)] = mSt;
      mLink[int'(tm)] = curPc;
      mSt[4:0] = tm;
      mSt[5] = 1'b0;
      mSt[24] = 1'b0;
      mSt[7] = 1'b1;
      if (k == 0 || k == 7) mSt[6] = 1'b1;
      mPc = 32'(k * 4);
      mCode = 3'(k);
    end else if (acc) begin
      mSt = mSaved.exists(int'(md)) ? mSaved[int'(md)] : 32'h0;
      mPc = mLink.exists(int'(md)) ? mLink[int'(md)] : 32'h0;
    end else if (statusWr) begin
      mSt = statusWrData & 32'hF900_00FF;
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // inputs are set just after a falling edge; advance one cycle and compare
  task automatic step(input string tag);
    modelStep();
    @(negedge clk);
    chk(tag, "status", statusOut, mSt);
    chk(tag, "pcNext", pcNext, mPc);
    chk(tag, "pcLoad", 32'(pcLoad), 32'(mLoad));
    chk(tag, "excTaken", 32'(excTaken), 32'(mTaken));
    chk(tag, "excCode", 32'(excCode), 32'(mCode));
    chk(tag, "retTaken", 32'(retTaken), 32'(mRet));
  endtask

  task automatic idle();
    {reqReset, reqUndef, reqSwi, reqPabt, reqDabt, irqReq, fiqReq} = '0;
    {execDone, retStrobe, statusWr} = '0;
  endtask

  task automatic writeStat(input logic [31:0] v);
    idle();
    statusWr = 1; statusWrData = v;
    step("R2");
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "status", statusOut, 32'h0000_00D3);
    chk("R1", "pcNext", pcNext, 32'h0);
    chk("R1", "pulses", {29'd0, pcLoad, excTaken, retTaken}, 32'h0);

    writeStat(32'hFFFF_FFFF);
    writeStat(32'hF000_0010);

    // software interrupt from user mode
    curPc = 32'h0000_1000; execDone = 1; reqSwi = 1;
    step("R4");
    chk("R5", "fiq mask kept", 32'(statusOut[6]), 32'h0);
    idle();
    step("R13");
    retStrobe = 1;
    step("R11");
    chk("R3", "restored status", statusOut, 32'hF000_0010);
    chk("R7", "restored pc", pcNext, 32'h0000_1000);
    idle();

    // data abort waits for execDone
    curPc = 32'h0000_2000; reqDabt = 1;
    step("R8");
    execDone = 1;
    step("R8");
    idle();
    // IRQ masked in abort mode, FIQ still allowed
    curPc = 32'h0000_3000; execDone = 1; irqReq = 1;
    step("R10");
    irqReq = 0; fiqReq = 1;
    step("R5");
    idle();
    retStrobe = 1;
    step("R11");
    step("R11");
    idle();

    // everything at once except reset: data abort wins
    writeStat(32'h0000_0010);
    {reqUndef, reqSwi, reqPabt, reqDabt, irqReq, fiqReq, execDone} = '1;
    step("R9");
    idle();
    writeStat(32'h0000_0010);
    {fiqReq, irqReq, reqPabt, reqUndef, execDone} = '1;
    step("R9");
    idle();
    {reqReset, reqDabt, fiqReq} = '1;
    step("R9");
    idle();

    // entry beats return and write in the same cycle
    writeStat(32'h0000_0013);
    curPc = 32'h0000_4000; reqUndef = 1; execDone = 1; retStrobe = 1;
    statusWr = 1; statusWrData = 32'h0000_0010;
    step("R12");
    idle();
    retStrobe = 1; statusWr = 1; statusWrData = 32'h0000_001F;
    step("R12");
    idle();

    // ignored returns
    writeStat(32'h0000_0033);
    retStrobe = 1;
    step("R11");
    idle();
    writeStat(32'h0100_0013);
    retStrobe = 1;
    step("R11");
    idle();
    writeStat(32'h0000_0010);
    retStrobe = 1;
    step("R11");
    idle();

    // each vector in turn
    for (int k = 0; k < 8; k++) begin
      if (k == 5) continue;
      writeStat(32'h0000_0010);
      curPc = 32'h100 * (k + 1);
      execDone = 1;
      case (k)
        0: reqReset = 1;
        1: reqUndef = 1;
        2: reqSwi = 1;
        3: reqPabt = 1;
        4: reqDabt = 1;
        6: irqReq = 1;
        default: fiqReq = 1;
      endcase
      step("R6");
      idle();
    end

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] modes [8] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h05};
      reqReset  = ($urandom_range(0, 63) == 0);
      reqUndef  = ($urandom_range(0, 7) == 0);
      reqSwi    = ($urandom_range(0, 7) == 0);
      reqPabt   = ($urandom_range(0, 7) == 0);
      reqDabt   = ($urandom_range(0, 9) == 0);
      irqReq    = ($urandom_range(0, 3) == 0);
      fiqReq    = ($urandom_range(0, 5) == 0);
      execDone  = ($urandom_range(0, 3) != 0);
      retStrobe = ($urandom_range(0, 4) == 0);
      statusWr  = ($urandom_range(0, 6) == 0);
      statusWrData = $urandom;
      statusWrData[4:0] = modes[$urandom_range(0, 7)];
      if ($urandom_range(0, 3) != 0) statusWrData[7:5] = 3'($urandom_range(0, 3) << 1);
      if ($urandom_range(0, 3) != 0) statusWrData[24] = 1'b0;
      curPc = $urandom;
      step("R9");
    end
    idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule